// File: doc/BRIEF.md
# UART Interrupt Identification and Request

This block decides which interrupt a 16550-style serial port reports and drives its single interrupt request line. Five sources are ranked in a fixed order: line-status errors, receive character timeout, receive data available, transmit holding register empty, and modem-status change. The data queues, the baud generator and the modem pins sit outside the block. Their status arrives as plain level inputs or one-cycle event pulses.

The block keeps three pieces of state. The first is a four-bit enable register. The second is a sticky transmit-empty pending flag. The third is a pair of sticky line-status flags for overrun and break. Register accesses from the host bus reach the block as one-cycle strobes: enable write, holding-register write, identification read and line-status read. These strobes set or clear the pending state. The identification code is recomputed every cycle. It is captured into the read-data register only on the identification read strobe, so the value the host sees cannot change during its read. No data stream crosses the block edge, so all pins are plain control and status signals.

Top module: `iidp_ctrl`

## Requirements
- R1: A write strobe on `ier_wr` stores `ier_wdata[3:0]` into the enable register and drops bits 7:4. The stored value appears on `ier_o` from the next cycle. Enable bit 0 gates receive data and timeout, bit 1 gates transmit-empty, bit 2 gates line errors, and bit 3 gates modem change.
- R2: With enable bit 2 set and any line error flag set (overrun, parity, framing or break), the code is 0x6. This outranks every other source.
- R3: A pending receive timeout with enable bit 0 set gives code 0xC. This ranks just below line errors. With enable bit 0 clear, the timeout is ignored.
- R4: Receive data gives code 0x4. This needs enable bit 0 and `data_ready`, and either `fifo_en` low or `rx_count >= rx_trig`. It ranks third.
- R5: A set transmit-empty pending flag with enable bit 1 set gives code 0x2. It ranks fourth.
- R6: Any bit of `modem_delta` with enable bit 3 set gives code 0x0. It ranks last. When no source is active, the code is 0x1.
- R7: On an `id_rd` strobe, `id_rdata` captures the following value: bits 7:6 are 11 if `fifo_en` is high and 00 if it is low, bits 5:4 are 0, and bits 3:0 are the code. The captured value is readable from the next cycle and holds until the next strobe.
- R8: An identification read that captures code 0x2 clears the transmit-empty pending flag. A read that captures any other code leaves the flag unchanged.
- R9: The transmit-empty pending flag is set in two cases: by a rising edge of `thr_empty`, or by an enable write while `thr_empty` is high. A `thr_wr` strobe clears it. When a set and a clear fall in the same cycle, the set wins.
- R10: `line_err` is {break, framing, parity, overrun} at bits 3..0. Overrun and break are sticky. They are set by the `ovr_set` and `brk_set` pulses and cleared by an `lsr_rd` strobe. A set pulse in the same cycle as the strobe wins. Parity and framing follow their inputs and are not changed by `lsr_rd`.
- R11: `irq` is combinational and is high exactly when the current code is not 0x1.
- R12: After reset, the enables are 0, the pending and sticky flags are 0, `id_rdata` reads 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_o | output | 4 | Stored interrupt enables |
| thr_wr | input | 1 | Transmit holding register write strobe |
| thr_empty | input | 1 | Transmit holding register empty status |
| id_rd | input | 1 | Identification register read strobe |
| id_rdata | output | 8 | Identification value captured at the last read |
| lsr_rd | input | 1 | Line status register read strobe |
| ovr_set | input | 1 | Receive overrun event pulse |
| brk_set | input | 1 | Break received event pulse |
| par_err | input | 1 | Parity error status |
| frm_err | input | 1 | Framing error status |
| line_err | output | 4 | {break, framing, parity, overrun} flags |
| data_ready | input | 1 | Receive data available |
| fifo_en | input | 1 | Queues enabled |
| rx_count | input | CNT_W | Receive queue fill level |
| rx_trig | input | CNT_W | Receive trigger level |
| tmo_pend | input | 1 | Character timeout pending |
| modem_delta | input | 4 | Modem status change bits |
| irq | output | 1 | Interrupt request |

## Verification
`irq` is combinational, so it reflects a new input level in the same cycle. The bench samples it at the falling edge after driving inputs at the previous falling edge. Each strobe (enable write, holding write, line-status read, identification read) changes state at the rising edge that samples it. Its effect on `ier_o`, `line_err`, `irq` and `id_rdata` is therefore checked at the falling edge one half-cycle later. Every table vector first writes the enables, then sets the levels, checks `irq`, and then issues one identification read and checks the captured byte.

// File: rtl/iidp_pkg.sv
package iidp_pkg;

  typedef enum logic [3:0] {
    ID_MODEM = 4'h0,
    ID_NONE  = 4'h1,
    ID_TXE   = 4'h2,
    ID_RXD   = 4'h4,
    ID_LINE  = 4'h6,
    ID_TMO   = 4'hC
  } iid_code_e;

  localparam int NSRC = 5;

  // index 0 is the highest priority
  localparam iid_code_e SRC_CODE [NSRC] = '{ID_LINE, ID_TMO, ID_RXD, ID_TXE, ID_MODEM};

  localparam int SRC_LINE  = 0;
  localparam int SRC_TMO   = 1;
  localparam int SRC_RXD   = 2;
  localparam int SRC_TXE   = 3;
  localparam int SRC_MODEM = 4;

endpackage

// File: rtl/iidp_prio.sv
module iidp_prio
  import iidp_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req,
  output iid_code_e    code
);

  always_comb begin
    code = ID_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = SRC_CODE[i];
    end
  end

endmodule

// File: rtl/iidp_flags.sv
module iidp_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ier_wr,
  input  logic thr_wr,
  input  logic thr_empty,
  input  logic txe_read,
  input  logic lsr_rd,
  input  logic ovr_set,
  input  logic brk_set,
  output logic txe_pend,
  output logic ovr_q,
  output logic brk_q
);

  logic thr_empty_q;
  logic txe_arm;
  logic txe_clr;

  assign txe_arm = (thr_empty & ~thr_empty_q) | (ier_wr & thr_empty);
  assign txe_clr = thr_wr | txe_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_empty_q <= 1'b1;
      txe_pend    <= 1'b0;
      ovr_q       <= 1'b0;
      brk_q       <= 1'b0;
    end else begin
      thr_empty_q <= thr_empty;
      if (txe_arm)      txe_pend <= 1'b1;
      else if (txe_clr) txe_pend <= 1'b0;
      if (ovr_set)      ovr_q <= 1'b1;
      else if (lsr_rd)  ovr_q <= 1'b0;
      if (brk_set)      brk_q <= 1'b1;
      else if (lsr_rd)  brk_q <= 1'b0;
    end
  end

endmodule

// File: rtl/iidp_ctrl.sv
module iidp_ctrl
  import iidp_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  output logic [3:0]       ier_o,
  input  logic             thr_wr,
  input  logic             thr_empty,
  input  logic             id_rd,
  output logic [7:0]       id_rdata,
  input  logic             lsr_rd,
  input  logic             ovr_set,
  input  logic             brk_set,
  input  logic             par_err,
  input  logic             frm_err,
  output logic [3:0]       line_err,
  input  logic             data_ready,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             tmo_pend,
  input  logic [3:0]       modem_delta,
  output logic             irq
);

  localparam int EN_W = 4;

  logic [EN_W-1:0] en_q;
  logic            txe_pend, ovr_q, brk_q;
  logic [NSRC-1:0] req;
  iid_code_e       code;
  logic            unused_hi;

  assign unused_hi = ^ier_wdata[7:EN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (ier_wr) en_q <= ier_wdata[EN_W-1:0];
  end

  iidp_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ier_wr   (ier_wr),
    .thr_wr   (thr_wr),
    .thr_empty(thr_empty),
    .txe_read (id_rd && (code == ID_TXE)),
    .lsr_rd   (lsr_rd),
    .ovr_set  (ovr_set),
    .brk_set  (brk_set),
    .txe_pend (txe_pend),
    .ovr_q    (ovr_q),
    .brk_q    (brk_q)
  );

  assign line_err = {brk_q, frm_err, par_err, ovr_q};

  always_comb begin
    req            = '0;
    req[SRC_LINE]  = en_q[2] & (|line_err);
    req[SRC_TMO]   = en_q[0] & tmo_pend;
    req[SRC_RXD]   = en_q[0] & data_ready & (~fifo_en | (rx_count >= rx_trig));
    req[SRC_TXE]   = en_q[1] & txe_pend;
    req[SRC_MODEM] = en_q[3] & (|modem_delta);
  end

  iidp_prio #(.N(NSRC)) u_prio (
    .req (req),
    .code(code)
  );

  assign irq   = (code != ID_NONE);
  assign ier_o = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_rdata <= 8'h01;
    else if (id_rd) id_rdata <= {{2{fifo_en}}, 2'b00, code};
  end

endmodule

// File: rtl/iidp_ctrl_chk.sv
module iidp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_wr,
  input logic [7:0] ier_wdata,
  input logic [3:0] ier_o,
  input logic       id_rd,
  input logic [7:0] id_rdata,
  input logic       fifo_en,
  input logic       lsr_rd,
  input logic       ovr_set,
  input logic       brk_set,
  input logic [3:0] line_err,
  input logic       irq
);

  assert_ier_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier_o == $past(ier_wdata[3:0]));

  assert_id_top_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd |=> (id_rdata[7:6] == {2{$past(fifo_en)}}) && (id_rdata[5:4] == 2'b00));

  assert_irq_matches_id_R11: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd |=> (id_rdata[3:0] == 4'h1) == !$past(irq));

  assert_no_enable_no_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_o == 4'h0) |-> !irq);

  assert_lsr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr_set && !brk_set) |=> !line_err[0] && !line_err[3]);

  assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_set && brk_set) |=> line_err[0] && line_err[3]);

endmodule

bind iidp_ctrl iidp_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ier_wr   (ier_wr),
  .ier_wdata(ier_wdata),
  .ier_o    (ier_o),
  .id_rd    (id_rd),
  .id_rdata (id_rdata),
  .fifo_en  (fifo_en),
  .lsr_rd   (lsr_rd),
  .ovr_set  (ovr_set),
  .brk_set  (brk_set),
  .line_err (line_err),
  .irq      (irq)
);

// File: tb/iidp_ctrl_bench.sv
module iidp_ctrl_bench;

  localparam int CNT_W = 5;
  localparam int NV    = 14;

  // fields: en[30:27] pe[26] fe[25] tmo[24] dr[23] fen[22] cnt[21:17] trig[16:12] md[11:8] exp[7:0]
  localparam logic [30:0] VEC [NV] = '{
    {4'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0,  5'd0, 4'hF, 8'h01}, // R6 all masked
    {4'h4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd0, 4'h0, 8'h06}, // R2
    {4'hF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0,  5'd0, 4'h1, 8'h06}, // R2 over all
    {4'h1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0,  5'd0, 4'h0, 8'h0C}, // R3 over rx data
    {4'hE, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  5'd0, 4'h0, 8'h01}, // R3 gated
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd0, 4'h0, 8'h04}, // R4 fifo off
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd3,  5'd4, 4'h0, 8'hC1}, // R4 below trigger
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd4,  5'd4, 4'h0, 8'hC4}, // R4 at trigger
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd14, 5'd8, 4'h0, 8'hC4}, // R4 above trigger
    {4'h8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd0, 4'h2, 8'h00}, // R6 modem
    {4'h9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd0, 4'h4, 8'h04}, // R4 over modem
    {4'h7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd0, 4'hF, 8'h01}, // R6 modem masked
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd5,  5'd1, 4'h0, 8'hC1}, // R4 needs data_ready
    {4'hB, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd0,  5'd4, 4'h8, 8'hCC}  // R3 R7 fifo on
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ier_wr = 1'b0, thr_wr = 1'b0, thr_empty = 1'b0, id_rd = 1'b0;
  logic [7:0]       ier_wdata = 8'h00;
  logic             lsr_rd = 1'b0, ovr_set = 1'b0, brk_set = 1'b0;
  logic             par_err = 1'b0, frm_err = 1'b0, data_ready = 1'b0, fifo_en = 1'b0;
  logic [CNT_W-1:0] rx_count = '0, rx_trig = '0;
  logic             tmo_pend = 1'b0;
  logic [3:0]       modem_delta = 4'h0;
  logic [3:0]       ier_o;
  logic [7:0]       id_rdata;
  logic [3:0]       line_err;
  logic             irq;
  int               n_chk = 0, n_bad = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk;

  iidp_ctrl #(.CNT_W(CNT_W)) u_iidp_ctrl (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_o(ier_o),
    .thr_wr(thr_wr), .thr_empty(thr_empty), .id_rd(id_rd), .id_rdata(id_rdata),
    .lsr_rd(lsr_rd), .ovr_set(ovr_set), .brk_set(brk_set), .par_err(par_err),
    .frm_err(frm_err), .line_err(line_err), .data_ready(data_ready), .fifo_en(fifo_en),
    .rx_count(rx_count), .rx_trig(rx_trig), .tmo_pend(tmo_pend),
    .modem_delta(modem_delta), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_en(input logic [7:0] v);
    ier_wdata = v; ier_wr = 1'b1;
    @(negedge clk); ier_wr = 1'b0;
  endtask

  task automatic rd_id();
    id_rd = 1'b1;
    @(negedge clk); id_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 id", id_rdata, 8'h01);
    check("R12 irq", {7'd0, irq}, 8'h00);
    check("R12 en", {4'd0, ier_o}, 8'h00);
    check("R12 err", {4'd0, line_err}, 8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [30:0] v;
      v = VEC[k];
      wr_en({4'hA, v[30:27]});
      check("R1 en", {4'd0, ier_o}, {4'd0, v[30:27]});
      par_err = v[26]; frm_err = v[25]; tmo_pend = v[24]; data_ready = v[23];
      fifo_en = v[22]; rx_count = v[21:17]; rx_trig = v[16:12]; modem_delta = v[11:8];
      @(negedge clk);
      check("R11 irq", {7'd0, irq}, {7'd0, v[3:0] != 4'h1});
      rd_id();
      check("R2-6 R7 id", id_rdata, v[7:0]);
    end
    par_err = 0; frm_err = 0; tmo_pend = 0; data_ready = 0; fifo_en = 0; modem_delta = 0;

    // R9 rising edge arms, R8 read clears
    wr_en(8'h02);
    check("R9 idle", {7'd0, irq}, 8'h00);
    thr_empty = 1'b1;
    @(negedge clk);
    check("R9 edge", {7'd0, irq}, 8'h01);
    rd_id();
    check("R5 id", id_rdata, 8'h02);
    check("R8 cleared", {7'd0, irq}, 8'h00);
    rd_id();
    check("R8 next", id_rdata, 8'h01);
    // R9 enable write re-arms, holding write clears
    wr_en(8'h02);
    check("R9 rearm", {7'd0, irq}, 8'h01);
    thr_wr = 1'b1; @(negedge clk); thr_wr = 1'b0;
    check("R9 thr_wr", {7'd0, irq}, 8'h00);
    // R9 same-cycle set beats clear
    ier_wdata = 8'h02; ier_wr = 1'b1; thr_wr = 1'b1;
    @(negedge clk); ier_wr = 1'b0; thr_wr = 1'b0;
    check("R9 set wins", {7'd0, irq}, 8'h01);
    // R8 read of another code keeps the flag
    wr_en(8'h06);
    par_err = 1'b1;
    rd_id();
    check("R8 line id", id_rdata, 8'h06);
    par_err = 1'b0;
    @(negedge clk);
    check("R8 kept", {7'd0, irq}, 8'h01);
    rd_id();
    check("R8 txe id", id_rdata, 8'h02);

    // R10 sticky flags
    wr_en(8'h04);
    thr_empty = 1'b0;
    ovr_set = 1'b1; @(negedge clk); ovr_set = 1'b0;
    check("R10 ovr", {4'd0, line_err}, 8'h01);
    rd_id();
    check("R10 id", id_rdata, 8'h06);
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    check("R10 clr", {4'd0, line_err}, 8'h00);
    check("R10 irq", {7'd0, irq}, 8'h00);
    brk_set = 1'b1; @(negedge clk); brk_set = 1'b0;
    check("R10 brk", {4'd0, line_err}, 8'h08);
    par_err = 1'b1; frm_err = 1'b1;
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    check("R10 levels kept", {4'd0, line_err}, 8'h06);
    par_err = 1'b0; frm_err = 1'b0;
    ovr_set = 1'b1; lsr_rd = 1'b1; @(negedge clk); ovr_set = 1'b0; lsr_rd = 1'b0;
    check("R10 set wins", {4'd0, line_err}, 8'h01);
    check("R11 err irq", {7'd0, irq}, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule